// File: doc/BRIEF.md
# Period-Count Rollover Flag with Hysteresis

This block watches a 14-bit count of signal periods. It raises a sticky rollover flag whenever a single step of that count crosses one of the quarter-range boundaries (0, 4096, 8192 and 12288), in either direction. The counter is kept elsewhere. Each step comes with an up or down strobe, and the count input already shows the value after the step.

A small amount of boundary memory provides hysteresis. The block keeps the index of the last boundary it flagged. A later crossing of that same boundary, for example caused by jitter or a change of direction around it, is ignored. Only a crossing of a different boundary raises the flag again. Because the count moves one step at a time, that different boundary is always an adjacent one.

A host reads the position to acknowledge the flag. That read clears the rollover flag and the lost-rollover flag. The lost-rollover flag records that a second rollover arrived before the first one was acknowledged. An active-low interrupt follows the rollover flag while the interrupt enable is high.

Top module: `rollover_flag`

## Requirements
- R1: After reset both flags are clear, `irqN` is high, and the last-flagged boundary index is 0. A downward step from count 0 right after reset therefore raises no flag.
- R2: A cycle with `stepUp` high and `stepDown` low, where `count[11:0]` is 0, is an upward crossing of boundary `count[13:12]`. If that boundary index differs from the last-flagged index, the crossing is a rollover event. The event sets `rollFlag` on the next clock and records the index. The wrap from 16383 to 0 counts as a crossing of boundary 0.
- R3: A cycle with `stepDown` high and `stepUp` low, where `count[11:0]` is 0xFFF, is a downward departure from boundary `(count[13:12]+1) mod 4`. It is a rollover event under the same index rule as in R2.
- R4: A crossing whose boundary index equals the last-flagged index changes neither flag (hysteresis).
- R5: `readPos` without a rollover event clears both flags on the next clock.
- R6: A rollover event while `rollFlag` is set and `readPos` is low sets `lostFlag`. `lostFlag` then stays set until a read.
- R7: When `readPos` and a rollover event occur in the same clock, `rollFlag` ends set and `lostFlag` ends clear.
- R8: `irqN` is low exactly when `rollFlag` is set and `irqEn` is high. It follows `irqEn` with no clock delay.
- R9: A cycle with both step strobes high, or with neither, is not a crossing, whatever `count` shows.
- R10: `lostFlag` is never set while `rollFlag` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| count | input | 14 | Period count after this cycle's step |
| stepUp | input | 1 | Count moved up by one this cycle |
| stepDown | input | 1 | Count moved down by one this cycle |
| readPos | input | 1 | Position read strobe; acknowledges the flags |
| irqEn | input | 1 | Interrupt enable |
| rollFlag | output | 1 | Sticky rollover flag |
| lostFlag | output | 1 | A rollover arrived while the flag was still set |
| irqN | output | 1 | Interrupt, active low |

## Verification
The following properties are checked on every cycle:
- the lost flag implies the rollover flag;
- a read clears both flags;
- an unacknowledged second event sets the lost flag;
- an interrupt never appears without the flag;
- a double strobe never produces an event;
- no event ever targets the boundary that was last flagged.

Some behaviours can only be shown by the bench's scenarios:
- hysteresis seen from the outside, where reversing across a flagged boundary stays silent and the neighbouring boundary fires;
- the wrap from 16383 to 0;
- the post-reset silence at boundary 0;
- the outcome of a read and an event landing together.

// File: rtl/rollover_flag_pkg.sv
package rollover_flag_pkg;
  typedef struct packed {
    logic rollEvent;   // a new boundary was crossed this cycle
    logic ackRead;     // host read the position this cycle
  } flagStrobe_t;
endpackage

// File: rtl/rollover_ctrl.sv
module rollover_ctrl
  import rollover_flag_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int SEG_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] count,
  input  logic             stepUp,
  input  logic             stepDown,
  input  logic             readPos,
  output flagStrobe_t      strobes
);
  localparam int IDX_W = CNT_W - SEG_W;

  logic [SEG_W-1:0] segPos;
  logic [IDX_W-1:0] segIdx;
  logic [IDX_W-1:0] crossIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             upOnly, downOnly, hitUp, hitDown, fire;

  assign segPos   = count[SEG_W-1:0];
  assign segIdx   = count[CNT_W-1:SEG_W];
  assign upOnly   = stepUp & ~stepDown;
  assign downOnly = stepDown & ~stepUp;

  // upward: the step landed on a boundary; downward: the step left one
  assign hitUp    = upOnly && (segPos == '0);
  assign hitDown  = downOnly && (segPos == '1);
  assign crossIdx = hitDown ? segIdx + 1'b1 : segIdx;
  assign fire     = (hitUp || hitDown) && (crossIdx != lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastIdx <= '0;
    end else if (fire) begin
      lastIdx <= crossIdx;
    end
  end

  always_comb begin
    strobes.rollEvent = fire;
    strobes.ackRead   = readPos;
  end
endmodule

// File: rtl/rollover_datapath.sv
module rollover_datapath
  import rollover_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  flagStrobe_t strobes,
  output logic        rollFlag,
  output logic        lostFlag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rollFlag <= 1'b0;
      lostFlag <= 1'b0;
    end else if (strobes.rollEvent) begin
      rollFlag <= 1'b1;
      // a read in the same cycle acknowledges the old flag first
      lostFlag <= strobes.ackRead ? 1'b0 : (lostFlag | rollFlag);
    end else if (strobes.ackRead) begin
      rollFlag <= 1'b0;
      lostFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/rollover_flag.sv
module rollover_flag
  import rollover_flag_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int SEG_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] count,
  input  logic             stepUp,
  input  logic             stepDown,
  input  logic             readPos,
  input  logic             irqEn,
  output logic             rollFlag,
  output logic             lostFlag,
  output logic             irqN
);
  flagStrobe_t strobes;

  rollover_ctrl #(.CNT_W(CNT_W), .SEG_W(SEG_W)) ctrl (
    .clk(clk), .rstN(rstN), .count(count), .stepUp(stepUp),
    .stepDown(stepDown), .readPos(readPos), .strobes(strobes)
  );

  rollover_datapath dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rollFlag(rollFlag), .lostFlag(lostFlag)
  );

  assign irqN = ~(rollFlag & irqEn);
endmodule

// File: rtl/rollover_flag_chk.sv
module rollover_flag_chk
  import rollover_flag_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int SEG_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] count,
  input logic             stepUp,
  input logic             stepDown,
  input logic             readPos,
  input logic             rollFlag,
  input logic             lostFlag,
  input logic             irqN,
  input flagStrobe_t      strobes
);
  localparam int IDX_W = CNT_W - SEG_W;

  logic [IDX_W-1:0] seenIdx;
  logic [IDX_W-1:0] evIdx;
  assign evIdx = stepUp ? count[CNT_W-1:SEG_W] : count[CNT_W-1:SEG_W] + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenIdx <= '0;
    else if (strobes.rollEvent) seenIdx <= evIdx;
  end

  assert_event_sets_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rollEvent |=> rollFlag);
  assert_no_repeat_boundary_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rollEvent |-> (evIdx != seenIdx));
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (readPos && !strobes.rollEvent) |=> (!rollFlag && !lostFlag));
  assert_second_event_lost_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rollEvent && rollFlag && !readPos) |=> lostFlag);
  assert_read_event_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rollEvent && readPos) |=> (rollFlag && !lostFlag));
  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rollFlag |-> irqN);
  assert_double_strobe_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stepUp && stepDown) |-> !strobes.rollEvent);
  assert_lost_needs_roll_R10: assert property (@(posedge clk) disable iff (!rstN)
    lostFlag |-> rollFlag);
endmodule

bind rollover_flag rollover_flag_chk #(.CNT_W(CNT_W), .SEG_W(SEG_W)) chk (
  .clk(clk), .rstN(rstN), .count(count), .stepUp(stepUp), .stepDown(stepDown),
  .readPos(readPos), .rollFlag(rollFlag), .lostFlag(lostFlag), .irqN(irqN),
  .strobes(strobes)
);

// File: tb/rollover_flag_test.sv
module rollover_flag_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] count = '0;
  logic        stepUp = 1'b0, stepDown = 1'b0, readPos = 1'b0, irqEn = 1'b0;
  logic        rollFlag, lostFlag, irqN;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // reference state computed from the requirements
  logic       mRoll = 1'b0, mLost = 1'b0;
  logic [1:0] mLast = 2'd0;
  logic [13:0] pos = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rollover_flag uut (
    .clk(clk), .rstN(rstN), .count(count), .stepUp(stepUp), .stepDown(stepDown),
    .readPos(readPos), .irqEn(irqEn), .rollFlag(rollFlag), .lostFlag(lostFlag),
    .irqN(irqN)
  );

  function automatic logic expIrqN(input logic r, input logic en);
    return !(r && en);
  endfunction

  task automatic check(input logic act, input logic exp, input string what, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic modelStep(input logic [13:0] c, input logic u, input logic d, input logic r);
    logic hit;
    logic [1:0] idx;
    hit = 1'b0;
    idx = 2'd0;
    if (u && !d && c[11:0] == 12'h000) begin hit = 1'b1; idx = c[13:12]; end
    else if (d && !u && c[11:0] == 12'hFFF) begin hit = 1'b1; idx = c[13:12] + 2'd1; end
    if (hit && idx != mLast) begin
      mLast = idx;
      mLost = r ? 1'b0 : (mLost | mRoll);
      mRoll = 1'b1;
    end else if (r) begin
      mRoll = 1'b0;
      mLost = 1'b0;
    end
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic cycle(input logic [13:0] c, input logic u, input logic d, input logic r,
                       input string req);
    count = c; stepUp = u; stepDown = d; readPos = r;
    modelStep(c, u, d, r);
    @(negedge clk);
    stepUp = 1'b0; stepDown = 1'b0; readPos = 1'b0;
    check(rollFlag, mRoll, "rollFlag", req);
    check(lostFlag, mLost, "lostFlag", req);
    check(irqN, expIrqN(mRoll, irqEn), "irqN", req);
  endtask

  task automatic stepTo(input int dir, input string req);
    if (dir > 0) pos = pos + 14'd1; else pos = pos - 14'd1;
    cycle(pos, dir > 0, dir < 0, 1'b0, req);
  endtask

  task automatic jump(input logic [13:0] p);
    pos = p;
    cycle(pos, 1'b0, 1'b0, 1'b0, "R9");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int unsigned seed;
    int unsigned rnd;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (2) @(negedge clk);
    check(rollFlag, 1'b0, "rollFlag in reset", "R1");
    check(lostFlag, 1'b0, "lostFlag in reset", "R1");
    check(irqN, 1'b1, "irqN in reset", "R1");
    rstN = 1'b1;
    @(negedge clk);
    irqEn = 1'b1;

    // R1: down from 0 right after reset, boundary 0 is already last
    stepTo(-1, "R1");
    check(rollFlag, 1'b0, "no flag leaving 0 after reset", "R1");
    stepTo(1, "R4");
    check(rollFlag, 1'b0, "back onto 0 is same boundary", "R4");

    // R2: forward onto 4096
    jump(14'd4094);
    stepTo(1, "R2");
    stepTo(1, "R2");
    check(rollFlag, 1'b1, "flag at 4096", "R2");
    check(irqN, 1'b0, "irq asserted", "R8");
    // R4: jitter around 4096
    stepTo(-1, "R4");
    stepTo(1, "R4");
    stepTo(-1, "R4");
    check(lostFlag, 1'b0, "no re-fire at 4096", "R4");
    cycle(pos, 1'b0, 1'b0, 1'b1, "R5");
    check(rollFlag, 1'b0, "read clears roll", "R5");
    check(irqN, 1'b1, "irq released", "R8");

    // R3: down through 0 fires (neighbour of 4096)
    jump(14'd1);
    stepTo(-1, "R3");
    stepTo(-1, "R3");
    check(rollFlag, 1'b1, "flag leaving 0 downward", "R3");
    // R6: second event unacknowledged, leaving 12288 downward
    jump(14'd12289);
    stepTo(-1, "R6");
    stepTo(-1, "R6");
    check(lostFlag, 1'b1, "lost set", "R6");
    check(rollFlag, 1'b1, "roll still set", "R10");

    // R9: both strobes at a boundary-looking count
    cycle(14'd8191, 1'b1, 1'b1, 1'b0, "R9");
    cycle(14'd8192, 1'b1, 1'b1, 1'b0, "R9");
    check(lostFlag, 1'b1, "double strobe ignored", "R9");
    jump(14'd8192);

    // R7: read and event together
    jump(14'd8191);
    pos = 14'd8192;
    cycle(pos, 1'b1, 1'b0, 1'b1, "R7");
    check(rollFlag, 1'b1, "roll set by event", "R7");
    check(lostFlag, 1'b0, "lost cleared by read", "R7");

    // R8: enable acts combinationally
    irqEn = 1'b0;
    #1 check(irqN, 1'b1, "irq masked", "R8");
    irqEn = 1'b1;
    #1 check(irqN, 1'b0, "irq unmasked", "R8");

    // R2: wrap from 16383 to 0
    cycle(pos, 1'b0, 1'b0, 1'b1, "R5");
    jump(14'd16381);
    stepTo(1, "R2");
    stepTo(1, "R2");
    stepTo(1, "R2");
    check(rollFlag, 1'b1, "flag on wrap to 0", "R2");

    // random walk near boundaries
    for (int i = 0; i < 4000; i++) begin
      rnd = $urandom % 100;
      if ($urandom % 150 == 0) begin
        jump(14'({$urandom % 4, 12'h000} + 14'($urandom % 7) - 14'd3));
      end else if ($urandom % 40 == 0) begin
        irqEn = ~irqEn;
        cycle(pos, 1'b0, 1'b0, 1'b0, "R8");
      end else if (rnd < 45) begin
        pos = pos + 14'd1;
        cycle(pos, 1'b1, 1'b0, ($urandom % 20) == 0, "R2 random");
      end else if (rnd < 90) begin
        pos = pos - 14'd1;
        cycle(pos, 1'b0, 1'b1, ($urandom % 20) == 0, "R3 random");
      end else if (rnd < 95) begin
        cycle(pos, 1'b1, 1'b1, 1'b0, "R9 random");
      end else begin
        cycle(pos, 1'b0, 1'b0, 1'b1, "R5 random");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule